// File: doc/BRIEF.md
# Output Sample Pacing FIFO

This block sits after a filter stage whose results arrive in bursts or with irregular gaps. It spreads those samples out so that consecutive output samples are always at least a programmed number of clocks apart. A countdown timer decides when the next sample may leave. Samples that arrive while the timer is still running wait in a small first-in first-out store.

When the store is empty and the timer has already run out, an arriving sample skips the store and appears on the output on the next clock. Each output reloads the timer from the spacing input. The timer then counts down to zero and stays there until the next sample goes out. If the store already holds its full depth and nothing leaves in that cycle, a new sample is discarded and a sticky overflow flag is raised.

Top module: `pacer_fifo`

## Requirements
- R1: After reset, `out_valid` is 0, `empty` is 1, `overflow` is 0, and the timer is expired, so the first sample can pass straight through.
- R2: A sample offered while the store is empty and the timer is expired appears on `out_data` with `out_valid` high exactly one clock later.
- R3: Two successive `out_valid` pulses are never closer than `spacing + 1` clocks. `spacing` is a 12-bit count of clocks minus one, and a value of 0 allows an output on every clock.
- R4: A sample that arrives while the timer is still counting is stored. It leaves on the first clock where the timer is at zero, which is `spacing + 1` clocks after the previous output.
- R5: Samples leave in the order in which they arrived.
- R6: The store holds at most 4 samples. A sample offered while 4 are held and none leaves that cycle is dropped, and `overflow` is set and stays set until reset. The stored samples are unaffected.
- R7: `empty` is 1 exactly when no sample is held in the store. A sample that passes straight through never clears it.
- R8: When the timer reaches zero while the store holds samples, the oldest one is output on that clock. A sample arriving on the same clock is stored behind the others.
- R9: While the store stays non-empty, outputs follow one another at exactly `spacing + 1` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample |
| spacing | input | 12 | Minimum output spacing in clocks, minus one |
| out_valid | output | 1 | Paced output strobe |
| out_data | output | 16 | Paced output sample |
| overflow | output | 1 | Sticky flag: a sample was dropped |
| empty | output | 1 | Store holds no sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 12-bit spacing field and a depth of 4. The shallow store lets a six-sample burst reach the drop path. Spacing values of 0, 2, 3, 6 and 20 cover the fall-through case, a store that refills on the same clock it drains, the exact release distance for a single waiting sample, and a long hold in which the store fills completely.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int PACER_DATA_W = 16;
    localparam int PACER_DLY_W  = 12;
    localparam int PACER_DEPTH  = 4;
endpackage

// File: rtl/pacer_countdown.sv
module pacer_countdown #(
    parameter int DLY_W = pacer_pkg::PACER_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pacer_ring.sv
module pacer_ring #(
    parameter int DATA_W = pacer_pkg::PACER_DATA_W,
    parameter int DEPTH  = pacer_pkg::PACER_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr = bump(st_q.wr);
        if (rd_en) st_d.rd = bump(st_q.rd);
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr] <= wr_data;
    end

    assign rd_data = mem[st_q.rd];
    assign fill    = st_q.cnt;
endmodule

// File: rtl/pacer_fifo.sv
module pacer_fifo #(
    parameter int DATA_W = pacer_pkg::PACER_DATA_W,
    parameter int DLY_W  = pacer_pkg::PACER_DLY_W,
    parameter int DEPTH  = pacer_pkg::PACER_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DLY_W-1:0]  spacing,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              overflow,
    output logic              empty
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              ovf;
    } out_t;

    out_t st_d, st_q;

    logic              tmr_expired;
    logic [CW-1:0]     fill_cnt;
    logic [DATA_W-1:0] head;
    logic              held, emit, pop, push, drop, store;

    // decide what happens to the head and the incoming sample this clock
    always_comb begin
        held  = (fill_cnt != '0);
        pop   = tmr_expired && held;
        emit  = tmr_expired && (held || in_valid);
        push  = in_valid && !(tmr_expired && !held);
        drop  = push && (fill_cnt == CW'(DEPTH)) && !pop;
        store = push && !drop;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = emit;
        if (pop)       st_d.data = head;
        else if (emit) st_d.data = in_data;
        if (drop)      st_d.ovf  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pacer_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_data (in_data),
        .rd_en   (pop),
        .rd_data (head),
        .fill    (fill_cnt)
    );

    pacer_countdown #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (emit),
        .load_val (spacing),
        .expired  (tmr_expired)
    );

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign overflow  = st_q.ovf;
    assign empty     = !held;
endmodule

// File: rtl/pacer_fifo_chk.sv
module pacer_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [DATA_W-1:0]          in_data,
    input logic                       out_valid,
    input logic [DATA_W-1:0]          out_data,
    input logic                       overflow,
    input logic                       empty,
    input logic                       expired,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !expired |=> !out_valid);

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && fill != '0) |=> out_valid);

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && empty && in_valid) |=> (out_valid && out_data == $past(in_data)));

    // R7
    bypass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && fill == '0) |=> empty);
endmodule

bind pacer_fifo pacer_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overflow  (overflow),
    .empty     (empty),
    .expired   (tmr_expired),
    .fill      (fill_cnt)
);

// File: tb/pacer_fifo_bench.sv
`timescale 1ns/1ps
module pacer_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [11:0] spacing = '0;
    logic        out_valid, overflow, empty;
    logic [15:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_out = 0;
    int log_c [64];
    int log_d [64];

    always #4 clk = ~clk;

    pacer_fifo u_pacer_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .spacing(spacing), .out_valid(out_valid), .out_data(out_data),
        .overflow(overflow), .empty(empty)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (n_out < 64) begin
                log_c[n_out] = cyc;
                log_d[n_out] = int'(out_data);
            end
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic start(input int s);
        idle(30);
        spacing = 12'(s);
        n_out = 0;
    endtask

    // check count, consecutive values from base, and exact gaps
    task automatic expect_run(input string req, input int n, input int base, input int gap);
        chk(n_out == n, {req, " count"}, n_out, n);
        for (int i = 0; i < n && i < n_out; i++) begin
            chk(log_d[i] == base + i, {req, " order"}, log_d[i], base + i);
            if (i > 0)
                chk(log_c[i] - log_c[i-1] == gap, {req, " gap"}, log_c[i] - log_c[i-1], gap);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    endtask

    task automatic t_bypass;
        start(5);
        send(16'h0A5A);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 valid next clock", out_valid, 1);
        chk(out_data == 16'h0A5A, "R2 data", out_data, 16'h0A5A);
        chk(empty == 1'b1, "R7 bypass keeps empty", empty, 1);
        in_valid = 1'b0;
        idle(10);
    endtask

    task automatic t_fall_through;
        start(0);
        for (int i = 0; i < 5; i++) send(100 + i);
        idle(1);
        chk(empty == 1'b1, "R3 spacing 0 never stores", empty, 1);
        idle(5);
        expect_run("R3 spacing 0", 5, 100, 1);
    endtask

    task automatic t_burst;
        start(3);
        for (int i = 0; i < 4; i++) send(200 + i);
        idle(1);
        chk(empty == 1'b0, "R7 burst stored", empty, 0);
        idle(25);
        chk(empty == 1'b1, "R7 drained", empty, 1);
        expect_run("R9 R5 burst", 4, 200, 4);
        chk(overflow == 1'b0, "R6 no overflow", overflow, 0);
    endtask

    task automatic t_refill;
        start(2);
        send(300);
        send(301);
        idle(1);
        send(302);
        idle(15);
        expect_run("R8 refill", 3, 300, 3);
    endtask

    task automatic t_single_wait;
        start(6);
        send(400);
        idle(1);
        send(401);
        idle(15);
        expect_run("R4 single wait", 2, 400, 7);
    endtask

    task automatic t_overflow;
        start(20);
        for (int i = 0; i < 6; i++) send(500 + i);
        idle(1);
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        chk(empty == 1'b0, "R6 store full", empty, 0);
        idle(110);
        expect_run("R6 R3 overflow drain", 5, 500, 21);
        chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_fall_through();
        t_burst();
        t_refill();
        t_single_wait();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule